// File: doc/BRIEF.md
# Machine-Check Bank Error Logger

This block holds a small set of machine-check banks and decides what happens to each injected hardware error. Every bank keeps a status word, an address word and a misc word. A machine-check global status word is shared by all banks. The per-bank control masks, the global control mask, the capability word and the machine-check enable come in as configuration inputs. A read port returns the stored words.

Each injection carries a bank number, a status word, an address, a misc value, a global status value and an unconditional flag. One clock after the injection the block reports exactly one outcome. The outcome is one of these: rejected, ignored, suppressed, logged, overflow only, machine-check interrupt raised, or reset requested. The interrupt and the reset request are one-cycle pulses. Corrected errors never displace a pending uncorrected entry. An uncorrected error that arrives while a machine check is already being handled escalates to a reset.

Top module: `mcb_logger`

## Requirements
- R1: After reset, every bank status, address and misc word and the global status word read zero, and mceIrq, resetReq and resValid are low.
- R2: An injection is rejected with no state change, no pulse and the result code below, checked in this order. Code 8 is given when cfgCap is zero. Code 9 is given when injBank is not below cfgCap[7:0] or not below NUM_BANKS. Code 10 is given when status bit 63 (valid) is clear.
- R3: When status bit 55 (action required) is clear, global status bit 2 (in progress) is set and injUncond is low, the injection is ignored with code 2 and no state change.
- R4: For an uncorrected error (status bit 61), logging is suppressed with code 3 and no state change in two cases. The first is cfgCap bit 8 set with cfgMcgCtl not all ones. The second is the bank's control mask not all ones.
- R5: An uncorrected error that is not suppressed requests a reset if cfgMceEn is low or global status bit 2 is set. This gives code 4 and a resetReq pulse, and no state change.
- R6: Any other uncorrected error writes the bank address and misc words and the global status word. It also writes the bank status, with bit 62 (overflow) set when the old status had bit 63 set. It gives code 5 and an mceIrq pulse.
- R7: A corrected error over an invalid entry, or over a valid corrected entry, overwrites status, address and misc, with bit 62 set when the old entry was valid. It gives code 0.
- R8: A corrected error over a valid uncorrected entry only sets bit 62 of the existing status, keeps address and misc, and gives code 1.
- R9: resValid and resCode appear exactly one cycle after injValid. mceIrq and resetReq last one cycle and are never high together.
- R10: A pulse on mcipAck clears only bit 2 of the global status word. An injection that writes the global status word in the same cycle takes priority.
- R11: The read port is combinational. rdSel 0 returns status, 1 address, 2 misc (of bank rdBank, zero when rdBank is not below NUM_BANKS), and 3 the global status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgCap | input | 64 | Capability word: [7:0] bank count, [8] global control present |
| cfgMcgCtl | input | 64 | Global control mask |
| cfgBankCtl | input | NUM_BANKS*64 | Per-bank control masks, bank 0 in the low word |
| cfgMceEn | input | 1 | Machine-check exception enable |
| injValid | input | 1 | Injection strobe |
| injBank | input | 8 | Target bank number |
| injStatus | input | 64 | Error status word |
| injAddr | input | 64 | Error address |
| injMisc | input | 64 | Error misc word |
| injMcgStatus | input | 64 | Global status value for uncorrected logging |
| injUncond | input | 1 | Inject even while a machine check is in progress |
| mcipAck | input | 1 | Handler completion: clear in-progress bit |
| rdBank | input | 3 | Read bank select |
| rdSel | input | 2 | Read word select |
| rdData | output | 64 | Read data |
| mcgStatus | output | 64 | Global status word |
| mceIrq | output | 1 | Machine-check interrupt pulse |
| resetReq | output | 1 | Reset request pulse |
| resValid | output | 1 | Outcome valid |
| resCode | output | 4 | Outcome code |

## Verification
The bench builds the logger with NUM_BANKS at 4 and masks bank 3 off through its control word. Most of the sequence uses a capability count of 4. A later step raises the count to 6, so a bank number can pass the capability check but still fall outside the built banks. Four banks are enough to keep a corrected entry, an uncorrected entry, an empty bank and a masked bank side by side. This allows the overflow-only path, the ignore path and suppression to be hit in one run without a reset between them.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int WORD_W      = 64;
  localparam int BANK_IDX_W  = 3;
  localparam int MAX_BANKS   = 8;
  localparam int VAL_BIT     = 63;
  localparam int OVER_BIT    = 62;
  localparam int UC_BIT      = 61;
  localparam int AR_BIT      = 55;
  localparam int MCIP_BIT    = 2;
  localparam int CTLP_BIT    = 8;

  typedef enum logic [3:0] {
    RES_LOGGED    = 4'd0,
    RES_OVER_ONLY = 4'd1,
    RES_IGNORED   = 4'd2,
    RES_SUPPRESS  = 4'd3,
    RES_RESET     = 4'd4,
    RES_MCE       = 4'd5,
    RES_REJ_NOCAP = 4'd8,
    RES_REJ_BANK  = 4'd9,
    RES_REJ_NOVAL = 4'd10
  } res_e;

  typedef struct packed {
    logic wrEntry;
    logic overNew;
    logic overOnly;
    logic wrMcg;
  } strobe_t;
endpackage

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           cfgCap,
  input  logic [WORD_W-1:0]           cfgMcgCtl,
  input  logic [NUM_BANKS*WORD_W-1:0] cfgBankCtl,
  input  logic                        cfgMceEn,
  input  logic                        injValid,
  input  logic [7:0]                  injBank,
  input  logic                        stVal,
  input  logic                        stUc,
  input  logic                        stAr,
  input  logic                        injUncond,
  input  logic                        curVal,
  input  logic                        curUc,
  input  logic                        mcipNow,
  output strobe_t                     stb,
  output logic                        mceIrq,
  output logic                        resetReq,
  output logic                        resValid,
  output logic [3:0]                  resCode
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic              bankOk;
  logic [WORD_W-1:0] ctlSel;
  logic              ctlBlocked;
  res_e              code;

  assign bankOk = (injBank < cfgCap[7:0]) && (injBank < 8'(NUM_BANKS));

  always_comb begin
    ctlSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(injBank) == b) ctlSel = cfgBankCtl[b*WORD_W +: WORD_W];
    end
  end

  assign ctlBlocked = (cfgCap[CTLP_BIT] && (cfgMcgCtl != ALL_ONES)) ||
                      (ctlSel != ALL_ONES);

  always_comb begin
    stb  = '0;
    code = RES_LOGGED;
    if (cfgCap == '0) begin
      code = RES_REJ_NOCAP;
    end else if (!bankOk) begin
      code = RES_REJ_BANK;
    end else if (!stVal) begin
      code = RES_REJ_NOVAL;
    end else if (!injUncond && !stAr && mcipNow) begin
      code = RES_IGNORED;
    end else if (stUc) begin
      if (ctlBlocked) begin
        code = RES_SUPPRESS;
      end else if (!cfgMceEn || mcipNow) begin
        code = RES_RESET;
      end else begin
        code        = RES_MCE;
        stb.wrEntry = injValid;
        stb.wrMcg   = injValid;
        stb.overNew = curVal;
      end
    end else if (!curVal || !curUc) begin
      code        = RES_LOGGED;
      stb.wrEntry = injValid;
      stb.overNew = curVal;
    end else begin
      code         = RES_OVER_ONLY;
      stb.overOnly = injValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resCode  <= 4'd0;
      mceIrq   <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resValid <= injValid;
      resCode  <= injValid ? code : 4'd0;
      mceIrq   <= injValid && (code == RES_MCE);
      resetReq <= injValid && (code == RES_RESET);
    end
  end

  // R9: interrupt and reset never pulse together
  a_r9_irq_reset_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mceIrq && resetReq));

  // R9: outcome follows each injection by one cycle
  a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    injValid |=> resValid);

  // R2: a rejection raises no pulse
  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resCode[3]) |-> (!mceIrq && !resetReq));

  // R5: an enabled uncorrected error during a pending check escalates
  a_r5_escalate: assert property (@(posedge clk) disable iff (!rst_n)
    (injValid && stVal && stUc && (cfgCap != '0) && bankOk && mcipNow &&
     !ctlBlocked && (stAr || injUncond)) |=> resetReq);
endmodule

// File: rtl/mcb_datapath.sv
module mcb_datapath
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               stb,
  input  logic [BANK_IDX_W-1:0] selBank,
  input  logic [WORD_W-1:0]     injStatus,
  input  logic [WORD_W-1:0]     injAddr,
  input  logic [WORD_W-1:0]     injMisc,
  input  logic [WORD_W-1:0]     injMcgStatus,
  input  logic                  mcipAck,
  input  logic [BANK_IDX_W-1:0] rdBank,
  input  logic [1:0]            rdSel,
  output logic                  curVal,
  output logic                  curUc,
  output logic                  mcipNow,
  output logic [WORD_W-1:0]     mcgStatus,
  output logic [WORD_W-1:0]     rdData
);
  logic [WORD_W-1:0] statusQ [NUM_BANKS];
  logic [WORD_W-1:0] addrQ   [NUM_BANKS];
  logic [WORD_W-1:0] miscQ   [NUM_BANKS];
  logic [WORD_W-1:0] mcgQ;
  logic [WORD_W-1:0] curStatus;

  always_comb begin
    curStatus = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(selBank) == b) curStatus = statusQ[b];
    end
  end
  assign curVal = curStatus[VAL_BIT];
  assign curUc  = curStatus[UC_BIT];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (int'(selBank) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        statusQ[g] <= '0;
        addrQ[g]   <= '0;
        miscQ[g]   <= '0;
      end else if (hit && stb.wrEntry) begin
        statusQ[g] <= injStatus | (WORD_W'(stb.overNew) << OVER_BIT);
        addrQ[g]   <= injAddr;
        miscQ[g]   <= injMisc;
      end else if (hit && stb.overOnly) begin
        statusQ[g][OVER_BIT] <= 1'b1;
      end
    end

    // R7: a valid entry never loses its valid bit
    a_r7_val_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      statusQ[g][VAL_BIT] |=> statusQ[g][VAL_BIT]);

    // R8: overflow-only keeps address and misc, sets overflow
    a_r8_over_only_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && stb.overOnly) |=> ($stable(addrQ[g]) && $stable(miscQ[g]) &&
                                 statusQ[g][OVER_BIT]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcgQ <= '0;
    end else if (stb.wrMcg) begin
      mcgQ <= injMcgStatus;
    end else if (mcipAck) begin
      mcgQ[MCIP_BIT] <= 1'b0;
    end
  end

  assign mcipNow   = mcgQ[MCIP_BIT];
  assign mcgStatus = mcgQ;

  always_comb begin
    rdData = '0;
    if (rdSel == 2'd3) begin
      rdData = mcgQ;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(rdBank) == b) begin
          case (rdSel)
            2'd0:    rdData = statusQ[b];
            2'd1:    rdData = addrQ[b];
            default: rdData = miscQ[b];
          endcase
        end
      end
    end
  end

  // R10: acknowledge clears only the in-progress bit
  a_r10_ack_only_mcip: assert property (@(posedge clk) disable iff (!rst_n)
    (mcipAck && !stb.wrMcg) |=> (!mcgQ[MCIP_BIT] &&
      $stable(mcgQ[WORD_W-1:MCIP_BIT+1]) && $stable(mcgQ[MCIP_BIT-1:0])));
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [63:0]                 cfgCap,
  input  logic [63:0]                 cfgMcgCtl,
  input  logic [NUM_BANKS*64-1:0]     cfgBankCtl,
  input  logic                        cfgMceEn,
  input  logic                        injValid,
  input  logic [7:0]                  injBank,
  input  logic [63:0]                 injStatus,
  input  logic [63:0]                 injAddr,
  input  logic [63:0]                 injMisc,
  input  logic [63:0]                 injMcgStatus,
  input  logic                        injUncond,
  input  logic                        mcipAck,
  input  logic [2:0]                  rdBank,
  input  logic [1:0]                  rdSel,
  output logic [63:0]                 rdData,
  output logic [63:0]                 mcgStatus,
  output logic                        mceIrq,
  output logic                        resetReq,
  output logic                        resValid,
  output logic [3:0]                  resCode
);
  strobe_t stb;
  logic    curVal;
  logic    curUc;
  logic    mcipNow;

  initial begin
    if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS)
      $error("NUM_BANKS out of range");
  end

  mcb_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgCap    (cfgCap),
    .cfgMcgCtl (cfgMcgCtl),
    .cfgBankCtl(cfgBankCtl),
    .cfgMceEn  (cfgMceEn),
    .injValid  (injValid),
    .injBank   (injBank),
    .stVal     (injStatus[VAL_BIT]),
    .stUc      (injStatus[UC_BIT]),
    .stAr      (injStatus[AR_BIT]),
    .injUncond (injUncond),
    .curVal    (curVal),
    .curUc     (curUc),
    .mcipNow   (mcipNow),
    .stb       (stb),
    .mceIrq    (mceIrq),
    .resetReq  (resetReq),
    .resValid  (resValid),
    .resCode   (resCode)
  );

  mcb_datapath #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .selBank     (injBank[BANK_IDX_W-1:0]),
    .injStatus   (injStatus),
    .injAddr     (injAddr),
    .injMisc     (injMisc),
    .injMcgStatus(injMcgStatus),
    .mcipAck     (mcipAck),
    .rdBank      (rdBank),
    .rdSel       (rdSel),
    .curVal      (curVal),
    .curUc       (curUc),
    .mcipNow     (mcipNow),
    .mcgStatus   (mcgStatus),
    .rdData      (rdData)
  );
endmodule

// File: tb/mcb_logger_bench.sv
`timescale 1ns/1ps
module mcb_logger_bench;
  localparam int NB = 4;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] cfgCap = 64'h104;
  logic [63:0] cfgMcgCtl = ONES;
  logic [NB*64-1:0] cfgBankCtl = {64'h0, ONES, ONES, ONES};
  logic cfgMceEn = 1'b1;
  logic injValid = 1'b0;
  logic [7:0] injBank = '0;
  logic [63:0] injStatus = '0, injAddr = '0, injMisc = '0, injMcgStatus = '0;
  logic injUncond = 1'b0, mcipAck = 1'b0;
  logic [2:0] rdBank = '0;
  logic [1:0] rdSel = '0;
  logic [63:0] rdData, mcgStatus;
  logic mceIrq, resetReq, resValid;
  logic [3:0] resCode;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mcb_logger #(.NUM_BANKS(NB)) u_mcb_logger (
    .clk(clk), .rst_n(rst_n), .cfgCap(cfgCap), .cfgMcgCtl(cfgMcgCtl),
    .cfgBankCtl(cfgBankCtl), .cfgMceEn(cfgMceEn), .injValid(injValid),
    .injBank(injBank), .injStatus(injStatus), .injAddr(injAddr),
    .injMisc(injMisc), .injMcgStatus(injMcgStatus), .injUncond(injUncond),
    .mcipAck(mcipAck), .rdBank(rdBank), .rdSel(rdSel), .rdData(rdData),
    .mcgStatus(mcgStatus), .mceIrq(mceIrq), .resetReq(resetReq),
    .resValid(resValid), .resCode(resCode));

  typedef struct packed {
    logic [7:0]  bank;
    logic [63:0] status;
    logic [63:0] addr;
    logic [63:0] mcg;
    logic        uncond;
    logic [3:0]  code;
    logic        irq;
    logic        rst;
    logic [63:0] expStatus;
    logic [63:0] expAddr;
    logic [63:0] expMcg;
  } vec_t;

  // Sequence with cap count 4, global control present, bank 3 masked.
  localparam vec_t VECS [9] = '{
    '{8'd0, 64'h8000_0000_0000_0011, 64'h100, 64'h0, 1'b0, 4'd0,  1'b0, 1'b0, 64'h8000_0000_0000_0011, 64'h100, 64'h0}, // R7
    '{8'd0, 64'h8000_0000_0000_0012, 64'h200, 64'h0, 1'b0, 4'd0,  1'b0, 1'b0, 64'hC000_0000_0000_0012, 64'h200, 64'h0}, // R7 over
    '{8'd1, 64'hA000_0000_0000_0021, 64'h300, 64'h5, 1'b0, 4'd5,  1'b1, 1'b0, 64'hA000_0000_0000_0021, 64'h300, 64'h5}, // R6
    '{8'd1, 64'h8000_0000_0000_0013, 64'h400, 64'h0, 1'b1, 4'd1,  1'b0, 1'b0, 64'hE000_0000_0000_0021, 64'h300, 64'h5}, // R8
    '{8'd2, 64'h8000_0000_0000_0014, 64'h500, 64'h0, 1'b0, 4'd2,  1'b0, 1'b0, 64'h0, 64'h0, 64'h5},                    // R3
    '{8'd2, 64'hA080_0000_0000_0031, 64'h600, 64'h0, 1'b0, 4'd4,  1'b0, 1'b1, 64'h0, 64'h0, 64'h5},                    // R5
    '{8'd3, 64'hA080_0000_0000_0032, 64'h700, 64'h0, 1'b0, 4'd3,  1'b0, 1'b0, 64'h0, 64'h0, 64'h5},                    // R4
    '{8'd4, 64'h8000_0000_0000_0015, 64'h800, 64'h0, 1'b0, 4'd9,  1'b0, 1'b0, 64'h0, 64'h0, 64'h5},                    // R2
    '{8'd0, 64'h0000_0000_0000_0016, 64'h900, 64'h0, 1'b0, 4'd10, 1'b0, 1'b0, 64'hC000_0000_0000_0012, 64'h200, 64'h5} // R2
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] b, input logic [1:0] s, output logic [63:0] v);
    rdBank = b; rdSel = s; #1; v = rdData;
  endtask

  // Drives one injection; returns with outputs of that injection visible.
  task automatic inject(input logic [7:0] b, input logic [63:0] st, input logic [63:0] a,
                        input logic [63:0] m, input logic u);
    @(negedge clk);
    injValid = 1'b1; injBank = b; injStatus = st; injAddr = a;
    injMisc = a ^ 64'hFF; injMcgStatus = m; injUncond = u;
    @(negedge clk);
    injValid = 1'b0; injUncond = 1'b0;
  endtask

  task automatic outcome(input string req, input logic [3:0] code, input logic irq, input logic rq);
    chk({req, " resValid"}, 64'(resValid), 64'd1);
    chk({req, " resCode"}, 64'(resCode), 64'(code));
    chk({req, " mceIrq"}, 64'(mceIrq), 64'(irq));
    chk({req, " resetReq"}, 64'(resetReq), 64'(rq));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mceIrq", 64'(mceIrq), 0);
    chk("R1 resetReq", 64'(resetReq), 0);
    chk("R1 resValid", 64'(resValid), 0);
    chk("R1 mcgStatus", mcgStatus, 0);
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < 3; s++) begin
        rd(3'(b), 2'(s), v); chk("R1 bank word", v, 0);
      end
    end

    foreach (VECS[i]) begin
      inject(VECS[i].bank, VECS[i].status, VECS[i].addr, VECS[i].mcg, VECS[i].uncond);
      outcome($sformatf("vec%0d R2-R8", i), VECS[i].code, VECS[i].irq, VECS[i].rst);
      rd(VECS[i].bank[2:0], 2'd0, v); chk($sformatf("vec%0d status", i), v, VECS[i].expStatus);
      rd(VECS[i].bank[2:0], 2'd1, v); chk($sformatf("vec%0d addr", i), v, VECS[i].expAddr);
      rd(VECS[i].bank[2:0], 2'd2, v);
      chk($sformatf("vec%0d misc R11", i), v, VECS[i].expAddr == 0 ? 64'h0 : VECS[i].expAddr ^ 64'hFF);
      rd(3'd0, 2'd3, v); chk($sformatf("vec%0d mcg R11", i), v, VECS[i].expMcg);
    end

    // R10: acknowledge clears only bit 2
    @(negedge clk); mcipAck = 1'b1;
    @(negedge clk); mcipAck = 1'b0;
    chk("R10 ack", mcgStatus, 64'h1);

    // R6 after ack, then R9 pulse width
    inject(8'd2, 64'hA000_0000_0000_0041, 64'h800, 64'h1, 1'b0);
    outcome("R6 uc empty", 4'd5, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 irq one cycle", 64'(mceIrq), 0);
    chk("R9 resValid one cycle", 64'(resValid), 0);
    inject(8'd2, 64'hA000_0000_0000_0042, 64'h900, 64'h1, 1'b0);
    outcome("R6 uc over", 4'd5, 1'b1, 1'b0);
    rd(3'd2, 2'd0, v); chk("R6 over status", v, 64'hE000_0000_0000_0042);
    rd(3'd2, 2'd1, v); chk("R6 over addr", v, 64'h900);

    // R5: machine check disabled escalates
    cfgMceEn = 1'b0;
    inject(8'd0, 64'hA080_0000_0000_0051, 64'hA00, 64'h0, 1'b0);
    outcome("R5 mce disabled", 4'd4, 1'b0, 1'b1);
    rd(3'd0, 2'd0, v); chk("R5 no change", v, 64'hC000_0000_0000_0012);
    cfgMceEn = 1'b1;

    // R4: global mask with control-present capability
    cfgMcgCtl = 64'h0;
    inject(8'd0, 64'hA000_0000_0000_0061, 64'hB00, 64'h0, 1'b0);
    outcome("R4 global mask", 4'd3, 1'b0, 1'b0);
    rd(3'd0, 2'd1, v); chk("R4 no change", v, 64'h200);

    // R4: without control-present bit the global mask is not consulted
    cfgCap = 64'h004;
    inject(8'd0, 64'hA000_0000_0000_0061, 64'hB00, 64'h0, 1'b0);
    outcome("R4 no ctl present", 4'd5, 1'b1, 1'b0);
    rd(3'd0, 2'd0, v); chk("R6 over corrected", v, 64'hE000_0000_0000_0061);

    // R2: zero capability
    cfgCap = 64'h0;
    inject(8'd0, 64'h8000_0000_0000_0071, 64'hC00, 64'h0, 1'b0);
    outcome("R2 nocap", 4'd8, 1'b0, 1'b0);

    // R2: bank inside cap count but beyond the built banks
    cfgCap = 64'h106;
    inject(8'd5, 64'h8000_0000_0000_0072, 64'hD00, 64'h0, 1'b0);
    outcome("R2 bank beyond build", 4'd9, 1'b0, 1'b0);
    rd(3'd5, 2'd0, v); chk("R11 out of range read", v, 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule